// File: doc/BRIEF.md
# Instruction prefetch queue controller

This block is the bus-side front end of a small processor core. It owns the only memory port the core has. It fetches instruction bytes ahead of the execution side into a small byte-wide ring buffer. It reads from sequential addresses and starts a new transfer only when the buffer can take a whole bus transfer. The execution side takes one byte per cycle from a valid/pop port. When it needs a data read or write, it raises a request that this unit places on the same memory port, ahead of any pending prefetch.

A taken branch arrives on a redirect input with its target address. Every queued byte is thrown away and fetching restarts at the target. If a fetch is already on the bus when the redirect arrives, the unit lets that transfer finish and then drops its data. On a 16-bit bus, a fetch from an odd address moves a single byte so that the fetches after it are word-aligned. The bus width is a parameter, and the buffer depth follows from it: 6 bytes for a 2-byte bus and 4 bytes for a 1-byte bus.

Memory transfers use a level request held until a one-cycle acknowledge. Read data is valid in the acknowledge cycle.

Top module: `prefetch_queue`

## Requirements
- R1: The buffer holds at most 6 bytes when BUS_BYTES is 2, and at most 4 when BUS_BYTES is 1. With no fetch landing, a full buffer serves exactly that many pops before qValid goes low.
- R2: A prefetch is started only when the free space is at least BUS_BYTES bytes. A full buffer with one byte removed does not raise memReq on the 2-byte bus.
- R3: Bytes come out in ascending address order. After each completed fetch, the fetch address advances by the number of bytes moved. On the 2-byte bus with memWord=1, lane [7:0] holds the even address and lane [15:8] holds the next address.
- R4: A data request from the execution side wins over a prefetch that is ready in the same cycle. The bus then carries dAddr, dWe and dWdata with memWord=1. dDone is high in the cycle of memAck, with dRdata equal to memRdata. Prefetching resumes at the next sequential address afterwards.
- R5: A redirect empties the buffer, so qValid is low from the next cycle. The next fetch uses the target address.
- R6: If a fetch is in flight when a redirect arrives, its returned data is not queued and the fetch address is not advanced by it. The following fetch goes to the target.
- R7: A fetched byte can be popped from the cycle after the acknowledge that delivers it, even when the buffer was empty.
- R8: On the 2-byte bus, a fetch from an odd address uses memWord=0 and takes its byte from lane [15:8]. The fetch after it is a word transfer (memWord=1) from the next, even, address.
- R9: qValid is high exactly when the buffer is non-empty. A pop and an enqueue in the same cycle both take effect.
- R10: While reset is active, qValid and memReq are low. The first fetch after reset reads from RESET_VEC.
- R11: Once memReq is raised, it stays high with memAddr, memWe and memWdata unchanged until memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Memory transfer request, held until memAck |
| memAddr | output | ADDR_W | Byte address of the transfer |
| memWord | output | 1 | 1: full bus word, 0: single byte |
| memWe | output | 1 | 1: write, 0: read |
| memWdata | output | 8*BUS_BYTES | Write data |
| memAck | input | 1 | Transfer complete, read data valid |
| memRdata | input | 8*BUS_BYTES | Read data |
| qValid | output | 1 | Buffer holds at least one byte |
| qByte | output | 8 | Oldest queued instruction byte |
| qPop | input | 1 | Remove the oldest byte |
| dReq | input | 1 | Execution-side data access request, held until dDone |
| dWe | input | 1 | Data access is a write |
| dAddr | input | ADDR_W | Data access address |
| dWdata | input | 8*BUS_BYTES | Data access write data |
| dDone | output | 1 | Data access complete |
| dRdata | output | 8*BUS_BYTES | Data access read data |
| brTaken | input | 1 | Branch redirect strobe |
| brTarget | input | ADDR_W | Redirect target address |

## Verification
The hardest case to reach from the ports is a redirect that lands while a fetch is still waiting on the bus. The bench raises the memory model's latency to several cycles and redirects once to put the fetch address somewhere known. It then waits for the next memReq and pulses the redirect again before the acknowledge comes. After that it checks that the late data never shows up on qValid and that the next request uses the second target. The priority case is reached by draining a full buffer by exactly two bytes, so that a prefetch becomes eligible in the same cycle that the data request is raised.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DATA  = 2'd2
  } pfq_state_t;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic issueFetch;  // latch a prefetch onto the bus
    logic issueData;   // latch a data access onto the bus
    logic enq;         // returned fetch bytes go into the buffer
    logic flush;       // empty buffer, load fetch pointer from target
  } pfq_strobe_t;

  function automatic int depthFor(input int busBytes);
    return (busBytes == 2) ? 6 : 4;
  endfunction

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dReq,
  input  logic        brTaken,
  input  logic        memAck,
  input  logic        roomOk,
  output pfq_strobe_t strobe,
  output logic        memReq,
  output logic        dDone
);

  pfq_state_t state, nextState;
  logic stale, nextStale;

  always_comb begin
    nextState    = state;
    nextStale    = stale;
    strobe       = '0;
    strobe.flush = brTaken;
    unique case (state)
      ST_IDLE: begin
        if (dReq) begin
          strobe.issueData = 1'b1;
          nextState        = ST_DATA;
        end else if (roomOk && !brTaken) begin
          strobe.issueFetch = 1'b1;
          nextState         = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memAck) begin
          strobe.enq = !stale && !brTaken;
          nextStale  = 1'b0;
          nextState  = ST_IDLE;
        end else if (brTaken) begin
          nextStale = 1'b1;
        end
      end
      ST_DATA: begin
        if (memAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stale <= 1'b0;
    end else begin
      state <= nextState;
      stale <= nextStale;
    end
  end

  assign memReq = (state != ST_IDLE);
  assign dDone  = (state == ST_DATA) && memAck;

  // R4: a pending data request is served before any prefetch
  a_r4_data_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && dReq) |=> (state == ST_DATA));

  // R2: a prefetch only starts after the datapath reported room
  a_r2_room_on_issue: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && $past(state) == ST_IDLE) |-> $past(roomOk));

  // R6: a fetch that saw a redirect never enqueues
  a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && brTaken) |=> !strobe.enq);

endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pfq_strobe_t            strobe,
  input  logic                   popReq,
  input  logic [ADDR_W-1:0]      brTarget,
  input  logic [ADDR_W-1:0]      dAddr,
  input  logic                   dWe,
  input  logic [8*BUS_BYTES-1:0] dWdata,
  input  logic [8*BUS_BYTES-1:0] memRdata,
  output logic                   roomOk,
  output logic                   qValid,
  output logic [7:0]             qByte,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWord,
  output logic                   memWe,
  output logic [8*BUS_BYTES-1:0] memWdata
);

  localparam int DEPTH = depthFor(BUS_BYTES);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0]        store [DEPTH];
  logic [IDX_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] fetchPtr;
  logic [ADDR_W-1:0] busAddr;
  logic              busWord, busWe;
  logic [8*BUS_BYTES-1:0] busWdata;

  logic [1:0] enqN;
  logic [7:0] b0, b1;
  logic       doPop;
  logic [1:0] enqAmt;

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  // Lane selection depends on the bus width
  generate
    if (BUS_BYTES == 2) begin : g_word
      always_comb begin
        if (busWord) begin
          enqN = 2'd2;
          b0   = memRdata[7:0];
          b1   = memRdata[15:8];
        end else begin
          enqN = 2'd1;
          b0   = busAddr[0] ? memRdata[15:8] : memRdata[7:0];
          b1   = 8'h00;
        end
      end
    end else begin : g_byte
      always_comb begin
        enqN = 2'd1;
        b0   = memRdata[7:0];
        b1   = 8'h00;
      end
    end
  endgenerate

  assign doPop  = popReq && (count != '0);
  assign enqAmt = strobe.enq ? enqN : 2'd0;
  assign roomOk = (CNT_W'(DEPTH) - count) >= CNT_W'(BUS_BYTES);
  assign qValid = (count != '0);
  assign qByte  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.enq && !strobe.flush) begin
      store[wrPtr] <= b0;
      if (enqN == 2'd2) store[nextIdx(wrPtr)] <= b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      fetchPtr <= RESET_VEC;
      busAddr  <= '0;
      busWord  <= 1'b0;
      busWe    <= 1'b0;
      busWdata <= '0;
    end else begin
      if (strobe.flush) begin
        rdPtr    <= '0;
        wrPtr    <= '0;
        count    <= '0;
        fetchPtr <= brTarget;
      end else begin
        if (strobe.enq) begin
          wrPtr    <= (enqN == 2'd2) ? nextIdx(nextIdx(wrPtr)) : nextIdx(wrPtr);
          fetchPtr <= fetchPtr + ADDR_W'(enqN);
        end
        if (doPop) rdPtr <= nextIdx(rdPtr);
        count <= count + CNT_W'(enqAmt) - CNT_W'(doPop);
      end
      if (strobe.issueFetch) begin
        busAddr <= fetchPtr;
        busWord <= (BUS_BYTES == 2) && !fetchPtr[0];
        busWe   <= 1'b0;
      end else if (strobe.issueData) begin
        busAddr  <= dAddr;
        busWord  <= (BUS_BYTES == 2);
        busWe    <= dWe;
        busWdata <= dWdata;
      end
    end
  end

  assign memAddr  = busAddr;
  assign memWord  = busWord;
  assign memWe    = busWe;
  assign memWdata = busWdata;

  // R1: occupancy never exceeds the buffer depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R5: a redirect leaves the buffer empty
  a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (count == '0) && !qValid);

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] RESET_VEC = 20'hFFFF0
) (
  input  logic                   clk,
  input  logic                   rstN,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWord,
  output logic                   memWe,
  output logic [8*BUS_BYTES-1:0] memWdata,
  input  logic                   memAck,
  input  logic [8*BUS_BYTES-1:0] memRdata,
  output logic                   qValid,
  output logic [7:0]             qByte,
  input  logic                   qPop,
  input  logic                   dReq,
  input  logic                   dWe,
  input  logic [ADDR_W-1:0]      dAddr,
  input  logic [8*BUS_BYTES-1:0] dWdata,
  output logic                   dDone,
  output logic [8*BUS_BYTES-1:0] dRdata,
  input  logic                   brTaken,
  input  logic [ADDR_W-1:0]      brTarget
);

  pfq_strobe_t strobe;
  logic        roomOk;

  pfq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .dReq    (dReq),
    .brTaken (brTaken),
    .memAck  (memAck),
    .roomOk  (roomOk),
    .strobe  (strobe),
    .memReq  (memReq),
    .dDone   (dDone)
  );

  pfq_datapath #(
    .BUS_BYTES (BUS_BYTES),
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .popReq   (qPop),
    .brTarget (brTarget),
    .dAddr    (dAddr),
    .dWe      (dWe),
    .dWdata   (dWdata),
    .memRdata (memRdata),
    .roomOk   (roomOk),
    .qValid   (qValid),
    .qByte    (qByte),
    .memAddr  (memAddr),
    .memWord  (memWord),
    .memWe    (memWe),
    .memWdata (memWdata)
  );

  assign dRdata = memRdata;

  // R11: a raised request holds its address and control until acknowledged
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr) && $stable(memWe)
                              && $stable(memWdata));

endmodule

// File: tb/prefetch_queue_bench.sv
`timescale 1ns/1ps
module prefetch_queue_bench;

  localparam int BUS_BYTES = 2;
  localparam int ADDR_W    = 20;
  localparam logic [19:0] RV = 20'hFFFF0;

  logic        clk = 1'b0;
  logic        rstN;
  logic        memReq, memWord, memWe, memAck;
  logic [19:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic        qValid, qPop;
  logic [7:0]  qByte;
  logic        dReq, dWe, dDone;
  logic [19:0] dAddr;
  logic [15:0] dWdata, dRdata;
  logic        brTaken;
  logic [19:0] brTarget;

  int nChecks = 0;
  int nFail = 0;
  int lat = 1;
  int waitCnt = 0;
  logic [19:0] nextPop;

  always #2.5 clk = ~clk;

  prefetch_queue #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W), .RESET_VEC(RV)) u_prefetch_queue (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr), .memWord(memWord),
    .memWe(memWe), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .qValid(qValid), .qByte(qByte), .qPop(qPop), .dReq(dReq), .dWe(dWe),
    .dAddr(dAddr), .dWdata(dWdata), .dDone(dDone), .dRdata(dRdata),
    .brTaken(brTaken), .brTarget(brTarget)
  );

  function automatic logic [7:0] byteAt(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h3, a[19:16]};
  endfunction

  // Memory model: acknowledge after lat extra cycles
  always @(posedge clk) begin
    if (!rstN) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
      memRdata <= '0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (waitCnt >= lat) begin
          memAck  <= 1'b1;
          waitCnt <= 0;
          if (memWord)
            memRdata <= {byteAt(memAddr + 20'd1), byteAt(memAddr)};
          else if (memAddr[0])
            memRdata <= {byteAt(memAddr), 8'h00};
          else
            memRdata <= {8'h00, byteAt(memAddr)};
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitReq(input string req);
    for (int i = 0; i < 60; i++) begin
      if (memReq) return;
      @(negedge clk);
    end
    check(req, "memReq timeout", 0, 1);
  endtask

  task automatic waitAck(input string req);
    for (int i = 0; i < 60; i++) begin
      if (memAck) return;
      @(negedge clk);
    end
    check(req, "memAck timeout", 0, 1);
  endtask

  // Pop one byte, waiting for it if needed, and check its value
  task automatic popNext(input string req);
    for (int i = 0; i < 60 && !qValid; i++) @(negedge clk);
    check(req, "qValid before pop", {31'd0, qValid}, 1);
    check(req, "popped byte", {24'd0, qByte}, {24'd0, byteAt(nextPop)});
    qPop = 1'b1;
    @(negedge clk);
    qPop = 1'b0;
    nextPop = nextPop + 20'd1;
  endtask

  task automatic tReset();
    rstN = 1'b0; qPop = 0; dReq = 0; dWe = 0; dAddr = '0; dWdata = '0;
    brTaken = 0; brTarget = '0; lat = 1;
    repeat (4) @(negedge clk);
    check("R10", "qValid in reset", {31'd0, qValid}, 0);
    check("R10", "memReq in reset", {31'd0, memReq}, 0);
    rstN = 1'b1;
  endtask

  task automatic tFirstByte();
    @(negedge clk);
    waitReq("R10");
    check("R10", "first fetch address", {12'd0, memAddr}, {12'd0, RV});
    check("R3", "first fetch is a word", {31'd0, memWord}, 1);
    waitAck("R7");
    @(negedge clk);
    check("R7", "byte visible after ack", {31'd0, qValid}, 1);
    check("R7", "first byte value", {24'd0, qByte}, {24'd0, byteAt(RV)});
    nextPop = RV;
  endtask

  task automatic tFill();
    repeat (30) @(negedge clk);
    check("R2", "no request when full", {31'd0, memReq}, 0);
    lat = 20;
    for (int i = 0; i < 6; i++) popNext("R1");
    check("R1", "empty after six pops", {31'd0, qValid}, 0);
    lat = 1;
  endtask

  task automatic tRoom();
    int reqSeen = 0;
    repeat (40) @(negedge clk);
    popNext("R2");
    for (int i = 0; i < 6; i++) begin
      if (memReq) reqSeen++;
      @(negedge clk);
    end
    check("R2", "one free byte starts no fetch", reqSeen, 0);
    popNext("R2");
    waitReq("R2");
    check("R2", "fetch after two free", {12'd0, memAddr}, {12'd0, nextPop + 20'd4});
  endtask

  task automatic tStream();
    lat = 0;
    for (int i = 0; i < 24; i++) popNext("R9");
    lat = 1;
  endtask

  task automatic tDataRead();
    repeat (30) @(negedge clk);
    popNext("R4");
    qPop = 1'b1;
    check("R4", "popped byte", {24'd0, qByte}, {24'd0, byteAt(nextPop)});
    @(negedge clk);
    qPop = 1'b0;
    nextPop = nextPop + 20'd1;
    dReq = 1'b1; dWe = 1'b0; dAddr = 20'h12340;
    @(negedge clk);
    check("R4", "data request first", {31'd0, memReq}, 1);
    check("R4", "data address on bus", {12'd0, memAddr}, 32'h12340);
    check("R4", "read on bus", {31'd0, memWe}, 0);
    waitAck("R4");
    check("R4", "dDone with ack", {31'd0, dDone}, 1);
    check("R4", "read data", {16'd0, dRdata},
          {16'd0, byteAt(20'h12341), byteAt(20'h12340)});
    dReq = 1'b0;
    @(negedge clk);
    waitReq("R4");
    check("R4", "prefetch resumes", {12'd0, memAddr}, {12'd0, nextPop + 20'd4});
    check("R4", "resumed fetch is read", {31'd0, memWe}, 0);
  endtask

  task automatic tDataWrite();
    logic [19:0] held;
    lat = 4;
    dReq = 1'b1; dWe = 1'b1; dAddr = 20'h0ABC5; dWdata = 16'hBEEF;
    for (int i = 0; i < 60 && !(memReq && memWe); i++) @(negedge clk);
    check("R4", "write address", {12'd0, memAddr}, 32'h0ABC5);
    check("R4", "write data", {16'd0, memWdata}, 32'hBEEF);
    held = memAddr;
    for (int i = 0; i < 60 && !memAck; i++) begin
      check("R11", "request held", {31'd0, memReq}, 1);
      check("R11", "address held", {12'd0, memAddr}, {12'd0, held});
      @(negedge clk);
    end
    check("R4", "write done", {31'd0, dDone}, 1);
    dReq = 1'b0; dWe = 1'b0;
    lat = 1;
  endtask

  task automatic tRedirect();
    repeat (40) @(negedge clk);
    brTaken = 1'b1; brTarget = 20'h00101;
    @(negedge clk);
    brTaken = 1'b0;
    check("R5", "queue flushed", {31'd0, qValid}, 0);
    waitReq("R5");
    check("R5", "fetch at target", {12'd0, memAddr}, 32'h00101);
    check("R8", "odd fetch single byte", {31'd0, memWord}, 0);
    waitAck("R8");
    @(negedge clk);
    check("R8", "odd byte queued", {31'd0, qValid}, 1);
    check("R8", "odd byte from upper lane", {24'd0, qByte}, {24'd0, byteAt(20'h00101)});
    nextPop = 20'h00101;
    waitReq("R8");
    check("R8", "aligned follow-up", {12'd0, memAddr}, 32'h00102);
    check("R8", "follow-up is word", {31'd0, memWord}, 1);
    for (int i = 0; i < 5; i++) popNext("R3");
  endtask

  task automatic tInflight();
    lat = 6;
    repeat (40) @(negedge clk);
    brTaken = 1'b1; brTarget = 20'h00200;
    @(negedge clk);
    brTaken = 1'b0;
    waitReq("R6");
    check("R6", "fetch at first target", {12'd0, memAddr}, 32'h00200);
    check("R6", "still waiting", {31'd0, memAck}, 0);
    brTaken = 1'b1; brTarget = 20'h00300;
    @(negedge clk);
    brTaken = 1'b0;
    waitAck("R6");
    @(negedge clk);
    check("R6", "stale data dropped", {31'd0, qValid}, 0);
    waitReq("R6");
    check("R6", "fetch at second target", {12'd0, memAddr}, 32'h00300);
    waitAck("R6");
    @(negedge clk);
    nextPop = 20'h00300;
    popNext("R6");
    lat = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    tReset();
    tFirstByte();
    tFill();
    tRoom();
    tStream();
    tDataRead();
    tDataWrite();
    tRedirect();
    tInflight();
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule